// File: doc/BRIEF.md
# Base/Limit Address Relocation Unit

This block sits between a processor's address generator and the memory port. It holds two relocation registers: a base, which marks where the running process's partition begins in physical memory, and a limit, which gives the partition's length. Each access request carries a logical address. The unit adds the base to that address to form the physical address. It also compares the logical address with the limit. An access that fails the check is returned as a protection fault and no address is issued for it.

Only a requester in system mode can load the two registers. A write attempted in user mode leaves both registers unchanged and raises a one-cycle privilege-violation flag. Translation has one cycle of registered latency. Both the request side and the response side use valid/ready handshakes.

Top module: `reloc_unit`

## Requirements
- R1: After reset, base and limit are both 0, `rsp_valid` and `priv_viol` are low and `req_ready` is high. With these values, logical address 0 translates to physical 0 without a fault, and any nonzero logical address faults on the bound check.
- R2: For an access that passes both checks, `rsp_paddr` equals base plus the logical address. For example, base 0x9000 and logical 0x1204 give 0xA204.
- R3: A logical address strictly greater than the limit sets `rsp_fault_bound`. A logical address equal to the limit is allowed.
- R4: If base plus the logical address produces a carry out of the 16-bit address width, `rsp_fault_ovf` is set. The bound fault and the carry fault can be reported together.
- R5: Whenever either fault bit is set, `rsp_paddr` is 0, so no access is issued.
- R6: A write with `cfg_priv` high loads `cfg_wdata` into the base when `cfg_sel` is 0 and into the limit when `cfg_sel` is 1. Requests accepted after that clock edge use the new value.
- R7: A write with `cfg_priv` low changes neither register. It drives `priv_viol` high for exactly the one cycle that follows the attempt.
- R8: A request accepted on a clock edge (`req_valid` and `req_ready` both high) shows its result with `rsp_valid` high right after that edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields hold stable and `req_ready` is low. When `rsp_ready` is high, a new request can be accepted in the same cycle the held response is consumed.
- R10: A request accepted on the same edge as a system-mode register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_priv | input | 1 | High when the writer is in system mode |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | 16 | Write data |
| priv_viol | output | 1 | One-cycle pulse after a user-mode write attempt |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_laddr | input | 16 | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer can take the response |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_fault_bound | output | 1 | Logical address above limit |
| rsp_fault_ovf | output | 1 | Relocation carried out of the address width |

## Verification
Two situations are the hardest to set up from the ports. The first is a request that is accepted on the same clock edge as a register write. The second is a new request that enters while a stalled response is being released. The bench reaches the first by asserting the write strobe and `req_valid` after the same falling edge, then checks that the result uses the old base and that the next request uses the new one. It reaches the second by holding `rsp_ready` low with a second request already waiting, then raising `rsp_ready`, so that consuming the old response and accepting the new request share one edge.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } cfg_sel_e;

  typedef struct packed {
    logic bound;
    logic ovf;
  } fault_t;

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic                  cfg_priv,
  input  reloc_pkg::cfg_sel_e   cfg_sel,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic [ADDR_W-1:0]     base_q,
  output logic [ADDR_W-1:0]     limit_q,
  output logic                  wr_accept,
  output logic                  wr_reject,
  output logic                  priv_viol
);

  // Privilege gate: only system-mode writes reach the registers.
  assign wr_accept = cfg_wr_en &  cfg_priv;
  assign wr_reject = cfg_wr_en & ~cfg_priv;

  logic base_we;
  logic limit_we;
  assign base_we  = wr_accept & (cfg_sel == reloc_pkg::SEL_BASE);
  assign limit_we = wr_accept & (cfg_sel == reloc_pkg::SEL_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
    end else if (limit_we) begin
      limit_q <= cfg_wdata;
    end
  end

  // Flag is registered: it is high for the cycle after the rejected write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= wr_reject;
    end
  end

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  limit,
  input  logic [ADDR_W-1:0]  laddr,
  output logic [ADDR_W-1:0]  paddr,
  output reloc_pkg::fault_t  fault
);

  localparam int SUM_W = ADDR_W + 1;

  // Widened sum, so that the top bit is the carry out.
  function automatic logic [SUM_W-1:0] reloc_sum(
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] l
  );
    return {1'b0, b} + {1'b0, l};
  endfunction

  function automatic logic above_limit(
    input logic [ADDR_W-1:0] l,
    input logic [ADDR_W-1:0] lim
  );
    return l > lim;
  endfunction

  logic [SUM_W-1:0] sum;
  logic             carry;
  logic             any_fault;

  assign sum         = reloc_sum(base, laddr);
  assign carry       = sum[SUM_W-1];
  assign fault.bound = above_limit(laddr, limit);
  assign fault.ovf   = carry;
  assign any_fault   = fault.bound | fault.ovf;
  assign paddr       = any_fault ? '0 : sum[ADDR_W-1:0];

endmodule

// File: rtl/reloc_outstage.sv
module reloc_outstage #(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_paddr,
  input  reloc_pkg::fault_t    in_fault,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_paddr,
  output reloc_pkg::fault_t    out_fault,
  output logic                 accept
);

  // One register slot: it accepts when empty or when being drained.
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_paddr <= '0;
      out_fault <= '0;
    end else if (accept) begin
      out_paddr <= in_paddr;
      out_fault <= in_fault;
    end
  end

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_priv,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              priv_viol,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault_bound,
  output logic              rsp_fault_ovf
);

  logic [ADDR_W-1:0]  base_q;
  logic [ADDR_W-1:0]  limit_q;
  logic               wr_accept;
  logic               wr_reject;
  logic [ADDR_W-1:0]  xl_paddr;
  reloc_pkg::fault_t  xl_fault;
  reloc_pkg::fault_t  rsp_fault;
  logic               req_accept;

  reloc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_priv  (cfg_priv),
    .cfg_sel   (reloc_pkg::cfg_sel_e'(cfg_sel)),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .limit_q   (limit_q),
    .wr_accept (wr_accept),
    .wr_reject (wr_reject),
    .priv_viol (priv_viol)
  );

  reloc_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .base  (base_q),
    .limit (limit_q),
    .laddr (req_laddr),
    .paddr (xl_paddr),
    .fault (xl_fault)
  );

  reloc_outstage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_paddr  (xl_paddr),
    .in_fault  (xl_fault),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_paddr (rsp_paddr),
    .out_fault (rsp_fault),
    .accept    (req_accept)
  );

  assign rsp_fault_bound = rsp_fault.bound;
  assign rsp_fault_ovf   = rsp_fault.ovf;

endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic              cfg_priv,
  input logic              priv_viol,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_laddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault_bound,
  input logic              rsp_fault_ovf,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic              wr_reject,
  input logic              req_accept
);

  AST_BOUND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> rsp_fault_bound == ($past(req_laddr) > $past(limit_q))); // R3

  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault_bound || rsp_fault_ovf)) |-> rsp_paddr == '0); // R5

  AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(base_q) && $stable(limit_q))); // R7

  AST_VIOL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_priv) |=> priv_viol); // R7

  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && !cfg_priv) |=> !priv_viol); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault_bound) && $stable(rsp_fault_ovf))); // R9

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R9

endmodule

bind reloc_unit reloc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_wr_en       (cfg_wr_en),
  .cfg_priv        (cfg_priv),
  .priv_viol       (priv_viol),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_laddr       (req_laddr),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_paddr       (rsp_paddr),
  .rsp_fault_bound (rsp_fault_bound),
  .rsp_fault_ovf   (rsp_fault_ovf),
  .base_q          (base_q),
  .limit_q         (limit_q),
  .wr_reject       (wr_reject),
  .req_accept      (req_accept)
);

// File: tb/test_reloc_unit.sv
`timescale 1ns/1ps
module test_reloc_unit;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_priv = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          priv_viol;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_laddr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_paddr;
  logic          rsp_fault_bound;
  logic          rsp_fault_ovf;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // Bench-side copies of the register contents, set by what the bench writes.
  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_limit = '0;

  always #2 clk = ~clk;

  reloc_unit #(.ADDR_W(AW)) i_reloc_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result from the requirements: sum, bound and carry.
  task automatic expect_of(input logic [AW-1:0] la, output logic [AW-1:0] pa,
                           output logic fb, output logic fo);
    int unsigned s;
    s  = int'(m_base) + int'(la);
    fb = (la > m_limit);
    fo = (s >= (1 << AW));
    pa = (fb || fo) ? '0 : AW'(s);
  endtask

  task automatic cfg_write(input bit priv, input bit sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (priv) begin
      if (sel) m_limit = d; else m_base = d;
    end
  endtask

  task automatic xlate(input logic [AW-1:0] la, input string tag);
    logic [AW-1:0] pa;
    logic fb, fo;
    expect_of(la, pa, fb, fo);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; rsp_ready = 1'b1;
    chk(req_ready === 1'b1, tag, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, tag, 32'(rsp_valid), 32'd1);
    chk(rsp_paddr === pa, tag, 32'(rsp_paddr), 32'(pa));
    chk({rsp_fault_bound, rsp_fault_ovf} === {fb, fo}, tag,
        32'({rsp_fault_bound, rsp_fault_ovf}), 32'({fb, fo}));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(priv_viol === 1'b0, "R1 priv_viol", 32'(priv_viol), 0);
    chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
    xlate(16'h0000, "R1 zero address");
    xlate(16'h0001, "R1 faults after reset");
  endtask

  task automatic t_program;
    cfg_write(1'b1, 1'b0, 16'h9000);
    cfg_write(1'b1, 1'b1, 16'h2000);
    chk(priv_viol === 1'b0, "R6 no viol on system write", 32'(priv_viol), 0);
    xlate(16'h1204, "R2 relocate");
    chk(rsp_paddr === 16'hA204, "R2 example", 32'(rsp_paddr), 32'hA204);
    xlate(16'h2000, "R3 equal to limit");
    xlate(16'h2001, "R3 above limit");
    chk(rsp_fault_bound === 1'b1, "R3 bound set", 32'(rsp_fault_bound), 1);
    chk(rsp_paddr === '0, "R5 no address", 32'(rsp_paddr), 0);
  endtask

  task automatic t_overflow;
    cfg_write(1'b1, 1'b0, 16'hF000);
    cfg_write(1'b1, 1'b1, 16'hFFFF);
    xlate(16'h0FFF, "R4 top of space");
    xlate(16'h1000, "R4 carry");
    chk(rsp_fault_ovf === 1'b1, "R4 ovf set", 32'(rsp_fault_ovf), 1);
    cfg_write(1'b1, 1'b1, 16'h0800);
    xlate(16'h1000, "R4 both faults");
    chk({rsp_fault_bound, rsp_fault_ovf} === 2'b11, "R4 both", 
        32'({rsp_fault_bound, rsp_fault_ovf}), 3);
  endtask

  task automatic t_user;
    cfg_write(1'b1, 1'b0, 16'h1000);
    cfg_write(1'b1, 1'b1, 16'h0100);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_priv = 1'b0; cfg_sel = 1'b0; cfg_wdata = 16'h4000;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk(priv_viol === 1'b1, "R7 viol pulse", 32'(priv_viol), 1);
    @(negedge clk);
    chk(priv_viol === 1'b0, "R7 viol one cycle", 32'(priv_viol), 0);
    cfg_write(1'b0, 1'b1, 16'hFFFF);
    xlate(16'h0050, "R7 base unchanged");
    xlate(16'h0200, "R7 limit unchanged");
  endtask

  task automatic t_stall;
    logic [AW-1:0] pa_a, pa_b;
    logic fb, fo;
    expect_of(16'h0010, pa_a, fb, fo);
    expect_of(16'h0020, pa_b, fb, fo);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_laddr = 16'h0010;
    @(negedge clk);
    req_laddr = 16'h0020;
    chk(rsp_valid === 1'b1, "R8 first response", 32'(rsp_valid), 1);
    chk(req_ready === 1'b0, "R9 ready low", 32'(req_ready), 0);
    repeat (2) @(negedge clk);
    chk(rsp_paddr === pa_a, "R9 held", 32'(rsp_paddr), 32'(pa_a));
    chk(req_ready === 1'b0, "R9 still blocked", 32'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 next valid", 32'(rsp_valid), 1);
    chk(rsp_paddr === pa_b, "R9 drain and accept", 32'(rsp_paddr), 32'(pa_b));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 empty", 32'(rsp_valid), 0);
  endtask

  task automatic t_same_edge;
    logic [AW-1:0] pa_old;
    logic fb, fo;
    expect_of(16'h0040, pa_old, fb, fo);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_priv = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h3000;
    req_valid = 1'b1; req_laddr = 16'h0040; rsp_ready = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    m_base = 16'h3000;
    chk(rsp_paddr === pa_old, "R10 old base used", 32'(rsp_paddr), 32'(pa_old));
    xlate(16'h0040, "R6 new base used");
    chk(rsp_paddr === 16'h3040, "R6 new base value", 32'(rsp_paddr), 32'h3040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_overflow();
    t_user();
    t_stall();
    t_same_edge();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule